// File: doc/BRIEF.md
# Secondary Processor Run and Program-Memory Window Controller

This block sits between a main processor and a secondary processor that share a program memory. The main processor writes a small control byte to hold the secondary in reset or let it run, and to take or give back the secondary's bus. While the main processor holds the bus, it sees one bank of the secondary's program memory through a fixed 128 KiB window in its own address map. The bank is picked by the top two bits of a mode byte.

Leaving reset is handled with care. Writing a value that puts the secondary into reset always keeps the bus with the main processor. A restart pulse is issued only on one exact exit: a write that lands on "running, bus released" after a reset was entered and before any restart pulse has used it up. On the secondary side, a write-protect byte shields the low part of program memory. Any write below that byte times 512, and inside the first 128 KiB, is dropped.

Top module: `subproc_ctl`

## Requirements
- R1: After reset, `sub_reset` is 1, `win_en` is 1, `sub_restart` is 0, `win_bank` is 0, the status word (`host_rd_sel`=0) reads 0x0002, and the write-protect byte is 0, so every secondary write passes.
- R2: In a control write (`host_sel`=0), bit 0 is run (1) or hold-in-reset (0) and bit 1 is bus request. When bit 0 is 0, bit 1 is stored as 1 whatever was written. Bits 7:2 are ignored.
- R3: A control write whose resulting 2-bit value equals the stored value changes nothing: no pulse, no output change.
- R4: A restart-pending flag is set at reset and whenever a control write leaves bit 0 at 0. A control write that changes the value to exactly 01 while the flag is set fires `sub_restart` and clears the flag. A later 01 value with the flag clear fires nothing.
- R5: `sub_restart` is registered. It is high for exactly one clock cycle, starting at the clock edge that stores the control write.
- R6: `win_en` equals the stored bus-request bit. A mode write (`host_sel`=1) sets `win_bank` to data bits 7:6. Both take effect from the clock edge of the write.
- R7: `win_hit` is 1 only when `win_en` is 1 and `host_mem_addr` lies in 0x020000..0x03FFFF. Then `win_ram_addr` is {`win_bank`, `host_mem_addr`[16:0]}.
- R8: `sub_cfg_wr` with `sub_cfg_sel`=0 loads the write-protect byte W. A request with `sub_wr_req`=1 yields `sub_wr_pass`=0 when the address is below 0x020000 and below W*512. Otherwise `sub_wr_pass` is 1.
- R9: The status word has bit 15 equal to bit 2 of the interrupt-mask byte (loaded by `sub_cfg_wr` with `sub_cfg_sel`=1) and bits 1:0 equal to the stored control value, with all other bits 0. `host_rd_sel`=1 returns {8'h00, `win_bank`, 6'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Main-side register byte write strobe |
| host_sel | input | 1 | Write target: 0 control, 1 mode |
| host_wdata | input | 8 | Main-side write byte |
| host_rd_sel | input | 1 | Read source: 0 status word, 1 mode |
| host_rdata | output | 16 | Main-side read data (combinational) |
| host_mem_addr | input | 24 | Main-side memory address for window decode |
| sub_cfg_wr | input | 1 | Secondary-side configuration write strobe |
| sub_cfg_sel | input | 1 | Configuration target: 0 write-protect, 1 interrupt mask |
| sub_cfg_wdata | input | 8 | Configuration write byte |
| sub_wr_req | input | 1 | Secondary program-memory write request |
| sub_wr_addr | input | 24 | Secondary program-memory write address |
| sub_wr_pass | output | 1 | Write allowed to reach memory |
| sub_reset | output | 1 | Hold secondary in reset |
| sub_restart | output | 1 | One-cycle restart pulse |
| win_en | output | 1 | Program-memory window enabled for main side |
| win_bank | output | 2 | Bank shown in the window |
| win_hit | output | 1 | Main address falls in the enabled window |
| win_ram_addr | output | 19 | Program-memory address for a window access |

## Verification
The control byte is driven through the sequences that tell the restart rule apart from simpler ones. The first release from power-on must pulse, and a repeated 01 write must not. Going through 11 before 01 must still pulse, because the pending flag survives that step. A second 11 then 01 must stay quiet because the flag was used up. Writes of 00 and of bytes with junk high bits show whether the forced bus-request bit is applied before the equality test. Window and write-protect checks sit on both sides of each boundary (window base and end, W*512 and the 128 KiB protected limit), so off-by-one compares and wrong shift amounts show up.

// File: rtl/subctl_pkg.sv
package subctl_pkg;

   // Control value bit positions (a neighbour decodes these)
   localparam int CTL_RUN_BIT = 0;
   localparam int CTL_BRQ_BIT = 1;

   typedef logic [1:0] ctl_val_t;

   localparam ctl_val_t CTL_POWERON = 2'b10;
   localparam ctl_val_t CTL_RUN_FREE = 2'b01;

   // Apply the hold-implies-bus rule to a raw control write
   function automatic ctl_val_t ctl_normalise(input logic [1:0] raw);
      ctl_val_t v;
      v = raw;
      if (!v[CTL_RUN_BIT])
         v[CTL_BRQ_BIT] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/subctl_runctl.sv
module subctl_runctl
   import subctl_pkg::*;
#(
   parameter bit PULSE_REGISTERED = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  logic [1:0] wr_val,
   output ctl_val_t ctl_q,
   output logic     restart_o
);

   ctl_val_t req_val;
   logic     changes;
   logic     pend_q;
   logic     fire;

   always_comb begin
      req_val = ctl_normalise(wr_val);
      changes = wr_en && (req_val != ctl_q);
      fire    = changes && (req_val == CTL_RUN_FREE) && pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_POWERON;
         pend_q <= 1'b1;
      end else if (changes) begin
         ctl_q <= req_val;
         if (!req_val[CTL_RUN_BIT])
            pend_q <= 1'b1;
         else if (fire)
            pend_q <= 1'b0;
      end
   end

   generate
      if (PULSE_REGISTERED) begin : g_pulse_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= fire;
         end
         assign restart_o = pulse_q;
      end else begin : g_pulse_comb
         assign restart_o = fire;
      end
   endgenerate

endmodule

// File: rtl/subctl_window.sv
module subctl_window #(
   parameter int ADDR_W   = 24,
   parameter int BANK_W   = 2,
   parameter int WIN_LOG2 = 17,
   parameter logic [ADDR_W-1:0] WIN_BASE = 24'h020000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_wr,
   input  logic [BANK_W-1:0]          mode_bank,
   input  logic                       brq,
   input  logic [ADDR_W-1:0]          mem_addr,
   output logic                       win_en,
   output logic [BANK_W-1:0]          win_bank,
   output logic                       win_hit,
   output logic [BANK_W+WIN_LOG2-1:0] win_ram_addr
);

   localparam int TAG_W = ADDR_W - WIN_LOG2;
   localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

   generate
      if (WIN_LOG2 >= ADDR_W || WIN_LOG2 < 1) begin : g_bad_log2
         $error("subctl_window: WIN_LOG2 out of range");
      end
      if (WIN_BASE[WIN_LOG2-1:0] != '0) begin : g_bad_base
         $error("subctl_window: WIN_BASE not aligned to window size");
      end
   endgenerate

   logic [BANK_W-1:0] bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bank_q <= '0;
      else if (mode_wr)
         bank_q <= mode_bank;
   end

   logic in_range;

   always_comb begin
      in_range     = (mem_addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
      win_en       = brq;
      win_bank     = bank_q;
      win_hit      = brq && in_range;
      win_ram_addr = {bank_q, mem_addr[WIN_LOG2-1:0]};
   end

endmodule

// File: rtl/subctl_wpfilter.sv
module subctl_wpfilter #(
   parameter int ADDR_W   = 24,
   parameter int WP_W     = 8,
   parameter int WP_SHIFT = 9,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = 24'h020000,
   parameter bit WP_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [WP_W-1:0]   cfg_val,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic [WP_W-1:0]   wp_q,
   output logic              pass
);

   generate
      if (WP_W + WP_SHIFT > ADDR_W) begin : g_bad_width
         $error("subctl_wpfilter: protect bound wider than address");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wp_q <= '0;
      else if (cfg_wr)
         wp_q <= cfg_val;
   end

   generate
      if (WP_ENABLE) begin : g_filter
         logic [ADDR_W-1:0] bound;
         logic              blocked;
         always_comb begin
            bound   = ADDR_W'(wp_q) << WP_SHIFT;
            blocked = (addr < PROT_LIMIT) && (addr < bound);
            pass    = req && !blocked;
         end
      end else begin : g_open
         assign pass = req;
      end
   endgenerate

endmodule

// File: rtl/subproc_ctl.sv
module subproc_ctl
   import subctl_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int BANK_W   = 2,
   parameter int WIN_LOG2 = 17,
   parameter int WP_W     = 8,
   parameter int WP_SHIFT = 9,
   parameter int MASK_BIT = 2,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 24'h020000,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = 24'h020000,
   localparam int RAM_AW = BANK_W + WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [7:0]        host_wdata,
   input  logic              host_rd_sel,
   output logic [15:0]       host_rdata,
   input  logic [ADDR_W-1:0] host_mem_addr,
   input  logic              sub_cfg_wr,
   input  logic              sub_cfg_sel,
   input  logic [WP_W-1:0]   sub_cfg_wdata,
   input  logic              sub_wr_req,
   input  logic [ADDR_W-1:0] sub_wr_addr,
   output logic              sub_wr_pass,
   output logic              sub_reset,
   output logic              sub_restart,
   output logic              win_en,
   output logic [BANK_W-1:0] win_bank,
   output logic              win_hit,
   output logic [RAM_AW-1:0] win_ram_addr
);

   generate
      if (BANK_W > 6) begin : g_bad_bank
         $error("subproc_ctl: bank field must fit above bit 1 of the mode byte");
      end
      if (MASK_BIT >= WP_W) begin : g_bad_mask
         $error("subproc_ctl: MASK_BIT outside configuration byte");
      end
   endgenerate

   ctl_val_t          ctl_cur;
   logic [WP_W-1:0]   wp_cur;
   logic              irq_mask_q;
   logic [3:0]        unused_hostbits;

   assign unused_hostbits = host_wdata[5:2];

   subctl_runctl #(
      .PULSE_REGISTERED(1'b1)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && !host_sel),
      .wr_val   (host_wdata[1:0]),
      .ctl_q    (ctl_cur),
      .restart_o(sub_restart)
   );

   subctl_window #(
      .ADDR_W  (ADDR_W),
      .BANK_W  (BANK_W),
      .WIN_LOG2(WIN_LOG2),
      .WIN_BASE(WIN_BASE)
   ) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (host_wr && host_sel),
      .mode_bank   (host_wdata[7 -: BANK_W]),
      .brq         (ctl_cur[CTL_BRQ_BIT]),
      .mem_addr    (host_mem_addr),
      .win_en      (win_en),
      .win_bank    (win_bank),
      .win_hit     (win_hit),
      .win_ram_addr(win_ram_addr)
   );

   subctl_wpfilter #(
      .ADDR_W    (ADDR_W),
      .WP_W      (WP_W),
      .WP_SHIFT  (WP_SHIFT),
      .PROT_LIMIT(PROT_LIMIT),
      .WP_ENABLE (1'b1)
   ) u_wp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_wr (sub_cfg_wr && !sub_cfg_sel),
      .cfg_val(sub_cfg_wdata),
      .req    (sub_wr_req),
      .addr   (sub_wr_addr),
      .wp_q   (wp_cur),
      .pass   (sub_wr_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_mask_q <= 1'b0;
      else if (sub_cfg_wr && sub_cfg_sel)
         irq_mask_q <= sub_cfg_wdata[MASK_BIT];
   end

   always_comb begin
      sub_reset  = !ctl_cur[CTL_RUN_BIT];
      host_rdata = '0;
      if (!host_rd_sel) begin
         host_rdata[15]  = irq_mask_q;
         host_rdata[1:0] = ctl_cur;
      end else begin
         host_rdata[7 -: BANK_W] = win_bank;
      end
   end

endmodule

// File: rtl/subproc_ctl_chk.sv
module subproc_ctl_chk #(
   parameter int ADDR_W   = 24,
   parameter int WP_W     = 8,
   parameter int WP_SHIFT = 9,
   parameter logic [ADDR_W-1:0] PROT_LIMIT = 24'h020000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_sel,
   input logic              sub_reset,
   input logic              sub_restart,
   input logic              win_en,
   input logic              win_hit,
   input logic              sub_wr_req,
   input logic [ADDR_W-1:0] sub_wr_addr,
   input logic              sub_wr_pass,
   input logic [WP_W-1:0]   wp_val
);

   AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      sub_reset |-> win_en); // R2

   AST_QUIET_NO_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && !host_sel) |=> ($stable(sub_reset) && $stable(win_en) && !sub_restart)); // R3

   AST_RESTART_ON_RUN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_restart |-> (!sub_reset && !win_en)); // R4

   AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_restart |=> !sub_restart); // R5

   AST_HIT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> win_en); // R7

   AST_WP_BLOCKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_wr_req && (sub_wr_addr < PROT_LIMIT)
       && (sub_wr_addr < (ADDR_W'(wp_val) << WP_SHIFT))) |-> !sub_wr_pass); // R8

   AST_WP_OPEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_wr_req && (sub_wr_addr >= PROT_LIMIT)) |-> sub_wr_pass); // R8

   AST_NO_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sub_wr_req |-> !sub_wr_pass); // R8

endmodule

bind subproc_ctl subproc_ctl_chk #(
   .ADDR_W    (ADDR_W),
   .WP_W      (WP_W),
   .WP_SHIFT  (WP_SHIFT),
   .PROT_LIMIT(PROT_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_sel   (host_sel),
   .sub_reset  (sub_reset),
   .sub_restart(sub_restart),
   .win_en     (win_en),
   .win_hit    (win_hit),
   .sub_wr_req (sub_wr_req),
   .sub_wr_addr(sub_wr_addr),
   .sub_wr_pass(sub_wr_pass),
   .wp_val     (wp_cur)
);

// File: tb/subproc_ctl_test.sv
`timescale 1ns/1ps
module subproc_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic        host_rd_sel = 1'b0;
   logic [15:0] host_rdata;
   logic [23:0] host_mem_addr = '0;
   logic        sub_cfg_wr = 1'b0;
   logic        sub_cfg_sel = 1'b0;
   logic [7:0]  sub_cfg_wdata = '0;
   logic        sub_wr_req = 1'b0;
   logic [23:0] sub_wr_addr = '0;
   logic        sub_wr_pass;
   logic        sub_reset;
   logic        sub_restart;
   logic        win_en;
   logic [1:0]  win_bank;
   logic        win_hit;
   logic [18:0] win_ram_addr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   subproc_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .host_rd_sel(host_rd_sel), .host_rdata(host_rdata),
      .host_mem_addr(host_mem_addr),
      .sub_cfg_wr(sub_cfg_wr), .sub_cfg_sel(sub_cfg_sel), .sub_cfg_wdata(sub_cfg_wdata),
      .sub_wr_req(sub_wr_req), .sub_wr_addr(sub_wr_addr), .sub_wr_pass(sub_wr_pass),
      .sub_reset(sub_reset), .sub_restart(sub_restart),
      .win_en(win_en), .win_bank(win_bank), .win_hit(win_hit),
      .win_ram_addr(win_ram_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One write cycle; returns at the falling edge after the storing edge
   task automatic host_write(input logic sel, input logic [7:0] data);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = data;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic cfg_write(input logic sel, input logic [7:0] data);
      @(negedge clk);
      sub_cfg_wr = 1'b1; sub_cfg_sel = sel; sub_cfg_wdata = data;
      @(negedge clk);
      sub_cfg_wr = 1'b0;
   endtask

   function automatic logic [15:0] status_rd();
      return host_rdata;
   endfunction

   // Write control byte and check status low bits and pulse (this cycle then next)
   task automatic ctl_step(input string req, input logic [7:0] data,
                           input logic [1:0] exp_val, input logic exp_pulse);
      host_write(1'b0, data);
      host_rd_sel = 1'b0;
      #1;
      check({req, " ctl value"}, status_rd() & 16'h0003, {14'b0, exp_val});
      check({req, " restart pulse"}, sub_restart, exp_pulse);
      @(negedge clk);
      check("R5 pulse one cycle", sub_restart, 1'b0);
   endtask

   task automatic t_reset();
      host_rd_sel = 1'b0;
      #1;
      check("R1 sub_reset", sub_reset, 1'b1);
      check("R1 win_en", win_en, 1'b1);
      check("R1 restart", sub_restart, 1'b0);
      check("R1 bank", win_bank, 2'd0);
      check("R1 status", status_rd(), 16'h0002);
      sub_wr_req = 1'b1; sub_wr_addr = 24'h000000;
      #1;
      check("R1 wp zero passes", sub_wr_pass, 1'b1);
      sub_wr_req = 1'b0;
   endtask

   task automatic t_restart_rules();
      ctl_step("R4 first release", 8'h01, 2'b01, 1'b1);
      check("R6 win_en off", win_en, 1'b0);
      check("R4 running", sub_reset, 1'b0);
      ctl_step("R3 repeat 01", 8'h01, 2'b01, 1'b0);
      ctl_step("R2 hold forces brq", 8'h00, 2'b10, 1'b0);
      check("R2 win_en forced", win_en, 1'b1);
      ctl_step("R2 junk bits ignored", 8'hFC, 2'b10, 1'b0);
      ctl_step("R4 run with bus", 8'h03, 2'b11, 1'b0);
      ctl_step("R4 pending survives", 8'h01, 2'b01, 1'b1);
      ctl_step("R4 to 11 again", 8'h03, 2'b11, 1'b0);
      ctl_step("R4 pending used up", 8'h01, 2'b01, 1'b0);
      ctl_step("R2 reset entry", 8'h02, 2'b10, 1'b0);
      ctl_step("R4 pulse after re-entry", 8'hFD, 2'b01, 1'b1);
   endtask

   task automatic t_window();
      ctl_step("R6 take bus", 8'h03, 2'b11, 1'b0);
      check("R6 win_en on", win_en, 1'b1);
      host_write(1'b1, 8'h80);
      check("R6 bank from 7:6", win_bank, 2'd2);
      host_rd_sel = 1'b1;
      #1;
      check("R9 mode readback", host_rdata, 16'h0080);
      host_rd_sel = 1'b0;
      host_mem_addr = 24'h021234;
      #1;
      check("R7 hit inside", win_hit, 1'b1);
      check("R7 ram addr", win_ram_addr, 19'h41234);
      host_mem_addr = 24'h020000; #1;
      check("R7 base edge", win_hit, 1'b1);
      host_mem_addr = 24'h03FFFF; #1;
      check("R7 top edge", win_hit, 1'b1);
      host_mem_addr = 24'h01FFFF; #1;
      check("R7 below base", win_hit, 1'b0);
      host_mem_addr = 24'h040000; #1;
      check("R7 above top", win_hit, 1'b0);
      host_write(1'b1, 8'h7F);
      check("R6 bank 1", win_bank, 2'd1);
      ctl_step("R6 release bus", 8'h01, 2'b01, 1'b0);
      host_mem_addr = 24'h021234; #1;
      check("R7 no grant no hit", win_hit, 1'b0);
   endtask

   task automatic probe_wp(input string req, input logic [23:0] a, input logic exp);
      sub_wr_req = 1'b1; sub_wr_addr = a;
      #1;
      check(req, sub_wr_pass, exp);
      sub_wr_req = 1'b0;
   endtask

   task automatic t_protect();
      cfg_write(1'b0, 8'h10);
      probe_wp("R8 below 0x2000", 24'h001FFE, 1'b0);
      probe_wp("R8 at 0x2000", 24'h002000, 1'b1);
      probe_wp("R8 high region", 24'h030000, 1'b1);
      cfg_write(1'b0, 8'hFF);
      probe_wp("R8 below 0x1FE00", 24'h01FDFF, 1'b0);
      probe_wp("R8 at 0x1FE00", 24'h01FE00, 1'b1);
      probe_wp("R8 at limit", 24'h020000, 1'b1);
      sub_wr_req = 1'b0; #1;
      check("R8 idle no pass", sub_wr_pass, 1'b0);
   endtask

   task automatic t_status();
      cfg_write(1'b1, 8'h04);
      host_rd_sel = 1'b0; #1;
      check("R9 mask bit 15", status_rd(), 16'h8001);
      cfg_write(1'b1, 8'hFB);
      #1;
      check("R9 mask cleared", status_rd(), 16'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_restart_rules();
      t_window();
      t_protect();
      t_status();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule